// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Strobe Sequencer

This block keeps an asynchronous-strobe DRAM refreshed. A free-running interval timer, whose period is given in clock cycles, marks each moment a refresh falls due. Each mark adds one to a bounded backlog of postponed refreshes. While that backlog is non-zero and no refresh is under way, the block asks the memory access controller for the bus. When the controller answers with a grant, the block drives the row and column strobes through one complete refresh cycle.

Two refresh styles are available, and a configuration input picks one at the moment of grant. In the column-first style the column strobe falls a set number of cycles before the row strobe, and the memory supplies the row address itself. In the row-only style the row strobe pulses on its own while the column strobe stays high. The controller presents the row address, which comes from a counter of its own that steps through every row and wraps. With the defaults (2048 rows, one request every 1560 cycles at 100 MHz, about 15.6 us) every row is refreshed within 32 ms.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is low, and on the first cycle after it, ras_n and cas_n are 1, busy and ref_req are 0, pend_cnt is 0 and row_addr is 0.
- R2: Once reset is released, the interval timer fires once every REFI_CYC cycles. Each firing adds one to pend_cnt, so ref_req first rises REFI_CYC cycles after release.
- R3: pend_cnt never exceeds PEND_MAX. A firing at PEND_MAX is dropped. A firing on the same edge as a refresh completion leaves pend_cnt unchanged.
- R4: ref_req is 1 exactly when pend_cnt is non-zero and busy is 0.
- R5: A refresh starts only on a clock edge at which ref_req and ref_gnt are both 1, and busy is 1 in the following cycle. With ref_gnt at 0, ras_n and cas_n stay 1.
- R6: In column-first mode (cfg_ras_only = 0), cas_n is 0 for CAS_LEAD cycles before ras_n falls. ras_n then stays 0 for RAS_LOW cycles with cas_n still 0.
- R7: In column-first mode the strobes are released in this order: ras_n rises first, and cas_n rises exactly one cycle later.
- R8: In row-only mode (cfg_ras_only = 1), cas_n stays 1 for the whole refresh. ras_n is 0 for RAS_LOW cycles, and row_addr holds steady throughout.
- R9: After both strobes are high, PRECHG cycles of precharge follow. busy then falls and pend_cnt drops by one. busy lasts CAS_LEAD+RAS_LOW+1+PRECHG cycles in column-first mode and RAS_LOW+PRECHG cycles in row-only mode.
- R10: row_addr advances by one after each completed row-only refresh, and wraps from 2^ROW_BITS-1 to 0. A column-first refresh leaves row_addr unchanged.
- R11: The mode is captured at grant. Changing cfg_ras_only while busy has no effect on the refresh in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ras_only | input | 1 | 1 selects the row-only style, 0 selects the column-first style |
| ref_gnt | input | 1 | Bus grant from the access controller |
| ref_req | output | 1 | Refresh request to the access controller |
| busy | output | 1 | Refresh cycle in progress |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | ROW_BITS (11) | Row presented during a row-only refresh |
| pend_cnt | output | $clog2(PEND_MAX+1) (4) | Postponed refresh backlog |

## Verification
The bench builds the block with REFI_CYC = 20, CAS_LEAD = 2, RAS_LOW = 3, PRECHG = 2, PEND_MAX = 8 and ROW_BITS = 3. The short interval lets the backlog reach its ceiling within a few hundred cycles. It also makes timer firings land on the same edge as refresh completions. With eight rows, the row counter wraps within the table of refresh vectors, and the short strobe phases allow every phase length to be counted cycle by cycle.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAS_LEAD,
    ST_RAS_LOW,
    ST_CAS_TAIL,
    ST_PRECHG
  } seq_state_t;

  // backlog step: one in, one out, bounded at lim
  function automatic int unsigned pend_step(int unsigned cur, logic inc, logic dec,
                                            int unsigned lim);
    if (inc && !dec && cur < lim) return cur + 1;
    if (dec && !inc && cur > 0) return cur - 1;
    return cur;
  endfunction

  // modular row step over rows entries
  function automatic int unsigned row_step(int unsigned cur, int unsigned rows);
    return (cur == rows - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned PERIOD = 1560
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + TW'(1);
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/ref_pending_counter.sv
module ref_pending_counter
  import dram_ref_pkg::*;
#(
  parameter int unsigned PEND_MAX = 8,
  parameter int unsigned PCW      = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           done,
  output logic [PCW-1:0] cnt,
  output logic           nonzero
);
  logic [PCW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= PCW'(pend_step(32'(cnt_q), tick, done, PEND_MAX));
  end

  assign cnt     = cnt_q;
  assign nonzero = (cnt_q != '0);
endmodule

// File: rtl/ref_row_counter.sv
module ref_row_counter
  import dram_ref_pkg::*;
#(
  parameter int unsigned ROW_BITS = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  output logic [ROW_BITS-1:0] row
);
  localparam int unsigned ROWS = 1 << ROW_BITS;

  logic [ROW_BITS-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   row_q <= '0;
    else if (adv) row_q <= ROW_BITS'(row_step(32'(row_q), ROWS));
  end

  assign row = row_q;
endmodule

// File: rtl/ref_strobe_seq.sv
module ref_strobe_seq
  import dram_ref_pkg::*;
#(
  parameter int unsigned CAS_LEAD = 2,
  parameter int unsigned RAS_LOW  = 4,
  parameter int unsigned PRECHG   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ras_only_in,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic done,
  output logic mode_q
);
  localparam int unsigned M1   = (CAS_LEAD > RAS_LOW) ? CAS_LEAD : RAS_LOW;
  localparam int unsigned MAXD = (M1 > PRECHG) ? M1 : PRECHG;
  localparam int unsigned DW   = (MAXD > 1) ? $clog2(MAXD) : 1;

  seq_state_t     st_q, st_d;
  logic [DW-1:0]  dly_q, dly_d;
  logic           mode_d;
  logic           phase_end;

  assign phase_end = (dly_q == '0);

  always_comb begin
    st_d   = st_q;
    dly_d  = phase_end ? dly_q : dly_q - DW'(1);
    mode_d = mode_q;
    case (st_q)
      ST_IDLE: begin
        dly_d = '0;
        if (start) begin
          mode_d = ras_only_in;
          if (ras_only_in) begin
            st_d  = ST_RAS_LOW;
            dly_d = DW'(RAS_LOW - 1);
          end else begin
            st_d  = ST_CAS_LEAD;
            dly_d = DW'(CAS_LEAD - 1);
          end
        end
      end
      ST_CAS_LEAD: if (phase_end) begin
        st_d  = ST_RAS_LOW;
        dly_d = DW'(RAS_LOW - 1);
      end
      ST_RAS_LOW: if (phase_end) begin
        if (mode_q) begin
          st_d  = ST_PRECHG;
          dly_d = DW'(PRECHG - 1);
        end else begin
          st_d  = ST_CAS_TAIL;
          dly_d = '0;
        end
      end
      ST_CAS_TAIL: begin
        st_d  = ST_PRECHG;
        dly_d = DW'(PRECHG - 1);
      end
      ST_PRECHG: if (phase_end) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dly_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      dly_q  <= dly_d;
      mode_q <= mode_d;
    end
  end

  assign busy  = (st_q != ST_IDLE);
  assign done  = (st_q == ST_PRECHG) && phase_end;
  assign ras_n = (st_q != ST_RAS_LOW);
  assign cas_n = !((st_q == ST_CAS_LEAD) || (st_q == ST_CAS_TAIL) ||
                   ((st_q == ST_RAS_LOW) && !mode_q));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int unsigned REFI_CYC = 1560,
  parameter int unsigned CAS_LEAD = 2,
  parameter int unsigned RAS_LOW  = 4,
  parameter int unsigned PRECHG   = 3,
  parameter int unsigned PEND_MAX = 8,
  parameter int unsigned ROW_BITS = 11,
  localparam int unsigned PCW     = $clog2(PEND_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_ras_only,
  input  logic                ref_gnt,
  output logic                ref_req,
  output logic                busy,
  output logic                ras_n,
  output logic                cas_n,
  output logic [ROW_BITS-1:0] row_addr,
  output logic [PCW-1:0]      pend_cnt
);
  // named internal events
  logic tick_evt;
  logic start_evt;
  logic done_evt;
  logic pend_nz;
  logic mode_q;
  logic row_adv;

  ref_interval_timer #(.PERIOD(REFI_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_evt)
  );

  ref_pending_counter #(.PEND_MAX(PEND_MAX), .PCW(PCW)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_evt),
    .done   (done_evt),
    .cnt    (pend_cnt),
    .nonzero(pend_nz)
  );

  assign ref_req   = pend_nz && !busy;
  assign start_evt = ref_req && ref_gnt;

  ref_strobe_seq #(.CAS_LEAD(CAS_LEAD), .RAS_LOW(RAS_LOW), .PRECHG(PRECHG)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_evt),
    .ras_only_in(cfg_ras_only),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .busy       (busy),
    .done       (done_evt),
    .mode_q     (mode_q)
  );

  assign row_adv = done_evt && mode_q;

  ref_row_counter #(.ROW_BITS(ROW_BITS)) u_row (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (row_adv),
    .row  (row_addr)
  );
endmodule

// File: rtl/ref_sched_checker.sv
module ref_sched_checker #(
  parameter int unsigned ROW_BITS = 11,
  parameter int unsigned PCW      = 4,
  parameter int unsigned PEND_MAX = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ref_req,
  input logic                ref_gnt,
  input logic                busy,
  input logic                ras_n,
  input logic                cas_n,
  input logic [ROW_BITS-1:0] row_addr,
  input logic [PCW-1:0]      pend_cnt,
  input logic                mode_q,
  input logic                done_evt,
  input logic                tick_evt
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pend_cnt) <= PEND_MAX);

  assert_req_only_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ref_req);

  assert_start_needs_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ref_req && ref_gnt));

  assert_cas_leads_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !mode_q) |-> $past(!cas_n));

  assert_ras_released_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> (ras_n && $past(ras_n)));

  assert_cas_high_row_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && mode_q) |-> cas_n);

  assert_pend_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !tick_evt) |=> (pend_cnt == $past(pend_cnt) - PCW'(1)));

  assert_row_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && mode_q) |=> (row_addr == ROW_BITS'($past(row_addr) + ROW_BITS'(1))));

  assert_row_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_evt && mode_q) |=> $stable(row_addr));
endmodule

bind dram_refresh_sched ref_sched_checker #(
  .ROW_BITS(ROW_BITS), .PCW(PCW), .PEND_MAX(PEND_MAX)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ref_req (ref_req),
  .ref_gnt (ref_gnt),
  .busy    (busy),
  .ras_n   (ras_n),
  .cas_n   (cas_n),
  .row_addr(row_addr),
  .pend_cnt(pend_cnt),
  .mode_q  (mode_q),
  .done_evt(done_evt),
  .tick_evt(tick_evt)
);

// File: tb/test_dram_refresh_sched.sv
`timescale 1ns/1ps
module test_dram_refresh_sched;
  localparam int REFI = 20;
  localparam int LEAD = 2;
  localparam int RLOW = 3;
  localparam int PRE  = 2;
  localparam int PMAX = 8;
  localparam int RB   = 3;
  localparam int PW   = $clog2(PMAX + 1);
  localparam int NROW = 1 << RB;
  localparam int NVEC = 12;
  // each vector: {row-only mode, flip cfg while busy}
  localparam int VEC [0:NVEC-1][0:1] = '{
    '{0,0}, '{1,0}, '{1,1}, '{0,1}, '{1,0}, '{1,0},
    '{0,0}, '{1,1}, '{1,0}, '{1,0}, '{1,0}, '{0,0}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_ras_only = 1'b0;
  logic          ref_gnt = 1'b0;
  logic          ref_req, busy, ras_n, cas_n;
  logic [RB-1:0] row_addr;
  logic [PW-1:0] pend_cnt;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_pend = 0;
  bit prev_busy = 0;
  int exp_row = 0;

  always #5 clk = ~clk;

  dram_refresh_sched #(
    .REFI_CYC(REFI), .CAS_LEAD(LEAD), .RAS_LOW(RLOW), .PRECHG(PRE),
    .PEND_MAX(PMAX), .ROW_BITS(RB)
  ) i_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .cfg_ras_only(cfg_ras_only), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .busy(busy), .ras_n(ras_n), .cas_n(cas_n),
    .row_addr(row_addr), .pend_cnt(pend_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // backlog and request model (R2, R3, R4, R9)
  always @(negedge clk) begin
    if (!rst_n) begin
      exp_pend  = 0;
      prev_busy = 0;
    end else begin
      bit inc, dec;
      inc = (cyc != 0) && (cyc % REFI == 0);
      dec = prev_busy && !busy;
      if (inc && !dec && exp_pend < PMAX) exp_pend++;
      else if (dec && !inc && exp_pend > 0) exp_pend--;
      chk(int'(pend_cnt) == exp_pend, "R3/R9 pend_cnt", int'(pend_cnt), exp_pend);
      chk(ref_req == (exp_pend != 0 && !busy), "R4 ref_req", int'(ref_req),
          int'(exp_pend != 0 && !busy));
      prev_busy = busy;
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  // one granted refresh; measures phases at negedges
  task automatic do_ref(input bit mode, input bit flip);
    int len, lead, rlow, tail, cas_bad, addr_bad;
    bit seen_ras;
    logic [RB-1:0] row0;
    while (!ref_req) @(negedge clk);
    cfg_ras_only = mode;
    ref_gnt = 1'b1;
    row0 = row_addr;
    @(negedge clk);
    ref_gnt = 1'b0;
    if (flip) cfg_ras_only = !mode;
    chk(busy == 1'b1, "R5 busy after grant", int'(busy), 1);
    len = 0; lead = 0; rlow = 0; tail = 0; cas_bad = 0; addr_bad = 0; seen_ras = 0;
    while (busy && len < 100) begin
      len++;
      if (!ras_n) begin
        seen_ras = 1;
        rlow++;
        if (mode && !cas_n) cas_bad++;
        if (!mode && cas_n) cas_bad++;
        if (row_addr != row0) addr_bad++;
      end else if (!cas_n) begin
        if (!seen_ras) lead++;
        else           tail++;
      end
      @(negedge clk);
    end
    if (mode) begin
      chk(len == RLOW + PRE, "R9/R11 row-only busy length", len, RLOW + PRE);
      chk(lead == 0 && tail == 0, "R8 cas idle row-only", lead + tail, 0);
      chk(cas_bad == 0, "R8 cas high during ras", cas_bad, 0);
      chk(addr_bad == 0, "R8 row steady", addr_bad, 0);
      exp_row = (exp_row + 1) % NROW;
    end else begin
      chk(len == LEAD + RLOW + 1 + PRE, "R9/R11 column-first busy length", len,
          LEAD + RLOW + 1 + PRE);
      chk(lead == LEAD, "R6 cas lead", lead, LEAD);
      chk(cas_bad == 0, "R6 cas low with ras", cas_bad, 0);
      chk(tail == 1, "R7 ras released first", tail, 1);
    end
    chk(rlow == RLOW, "R6/R8 ras low length", rlow, RLOW);
    chk(int'(row_addr) == exp_row, "R10 row_addr", int'(row_addr), exp_row);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ras_n && cas_n, "R1 strobes high", int'({ras_n, cas_n}), 3);
    chk(!busy && !ref_req, "R1 idle", int'({busy, ref_req}), 0);
    chk(pend_cnt == '0 && row_addr == '0, "R1 counters", int'(pend_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && !busy, "R1 first cycle out of reset", int'({ras_n, cas_n, busy}), 6);
    // R2: first request after REFI cycles
    n = 1;
    while (!ref_req && n < 1000) begin @(negedge clk); n++; end
    chk(n == REFI, "R2 first request", n, REFI);
    // R5: no grant, no strobes
    for (int i = 0; i < 6; i++) begin
      chk(!busy && ras_n && cas_n, "R5 no start without grant", int'({busy, ras_n, cas_n}), 3);
      @(negedge clk);
    end
    // table walk (R6-R11)
    for (int v = 0; v < NVEC; v++) do_ref(VEC[v][0] != 0, VEC[v][1] != 0);
    // R3: saturation with grant held low
    repeat (REFI * 10) @(negedge clk);
    chk(int'(pend_cnt) == PMAX, "R3 saturate", int'(pend_cnt), PMAX);
    for (int i = 0; i < 5; i++) do_ref(i[0], 1'b0);
    // R1: reset during a refresh
    while (!ref_req) @(negedge clk);
    cfg_ras_only = 1'b1;
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && ras_n && cas_n, "R1 reset mid refresh", int'({busy, ras_n, cas_n}), 3);
    chk(pend_cnt == '0 && row_addr == '0, "R1 counters cleared", int'(row_addr), 0);
    exp_row = 0;
    rst_n = 1'b1;
    do_ref(1'b1, 1'b0);
    finish_run();
  end
endmodule